// File: doc/BRIEF.md
# Reset Stretching and Sequencing Controller

This block turns an asynchronous, active-low board reset into a clean internal reset for a processor core and its pin groups. When the board reset falls, the block asserts the internal reset and floats the external pin groups at once, with no clock edge involved. When the board reset rises, the release is first synchronised into the input-clock domain. The internal reset is then held for a fixed stretch of input-clock cycles, and the outputs are released one after another in a set order.

While the internal reset is held, the core clock enable fires once in every eight input cycles, so the core runs at one eighth of the input rate. Three boot-configuration straps are captured once at the release and then stay fixed until the next reset. After reset the PLL is reported as bypassed. A register write, accepted only once the internal reset has ended, changes that flag.

The pin groups are the memory interface, the serial and timer pins, and the host and GPIO pins. All three, together with the bus-request valid flag, are enabled in one cycle. The two clock outputs that float during reset are then enabled, followed by the clock output that is held low during reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `int_rst_n` is 0 while `ext_rst_n` is 0. Count the rising edges of `clk_in` after `ext_rst_n` rises as E1, E2, and so on. `int_rst_n` becomes 1 at E514, which is 2 synchroniser edges plus a stretch of 512 cycles.
- R2: `cpu_clk_en` is 0 while `ext_rst_n` is 0. From the release until E514 it is 1 only in the cycle after an edge Ek where k mod 8 = 7. From E514 onward it is constantly 1.
- R3: `boot_cfg` is 0 while `ext_rst_n` is 0. At E2 it takes the value of `boot_straps`. Bit 2 carries strap pin 8, bit 1 carries strap pin 4 and bit 0 carries strap pin 3. Later changes on `boot_straps` have no effect until the next reset.
- R4: `mem_grp_oe` and `busreq_valid` go to 0 in the same time step in which `ext_rst_n` falls, without waiting for a clock edge.
- R5: `ser_grp_oe` and `host_grp_oe` go to 0 in the same time step in which `ext_rst_n` falls, without waiting for a clock edge.
- R6: `mem_grp_oe`, `busreq_valid`, `ser_grp_oe` and `host_grp_oe` all become 1 together at E515, one cycle after `int_rst_n` rises.
- R7: During reset, `eclk_oe` and `aux_clk_oe` are 0, meaning those outputs float. `tick_clk_run` is 0, meaning that output is driven low. After the release they become 1 at E516, E517 and E518 respectively, which is within 6 core-clock periods of `int_rst_n` rising.
- R8: `pll_bypass` is 1 during reset and after reset. While `int_rst_n` is 1, a cycle with `pll_wr_en` = 1 sets `pll_bypass` to the inverse of `pll_wr_engage` at the next edge. A write made while `int_rst_n` is 0 has no effect.
- R9: If `ext_rst_n` falls while the stretch is still counting, the count is discarded. The next release again takes the full 514 edges before `int_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| boot_straps | input | 3 | Boot strap pins {8, 4, 3} |
| pll_wr_en | input | 1 | PLL mode register write strobe |
| pll_wr_engage | input | 1 | Write data: 1 engages the PLL, 0 bypasses it |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| cpu_clk_en | output | 1 | Core clock enable |
| boot_cfg | output | 3 | Captured boot configuration |
| pll_bypass | output | 1 | PLL bypass flag |
| mem_grp_oe | output | 1 | Memory interface group output enable |
| busreq_valid | output | 1 | Bus-request output valid |
| ser_grp_oe | output | 1 | Serial/timer group output enable |
| host_grp_oe | output | 1 | Host/GPIO group output enable |
| eclk_oe | output | 1 | Memory clock output enable |
| aux_clk_oe | output | 1 | Auxiliary clock output enable |
| tick_clk_run | output | 1 | Third clock runs (0 = held low) |

## Verification
The assertions assume that `ext_rst_n` changes away from the rising clock edge. They also assume that the straps are steady from before the release until E2. The bench drives every input one time unit after a rising edge. It changes the straps only well before a release or long after E2, so no capture can be marginal. Reset is dropped both mid-stretch and after full release, which exercises the asynchronous floating of the groups and the restarted count.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    localparam int STRAP_W = 3;

    typedef struct packed {
        logic grp;
        logic eclk;
        logic aux;
        logic tick;
    } rel_en_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel,
    output logic rel_edge
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rel      = chain_q[STAGES-1];
    // The last stage is about to rise: this is the edge on which it sets.
    assign rel_edge = chain_q[STAGES-2] & ~chain_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int STRETCH = 512
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rel,
    output logic int_rst_n
);
    localparam int CW = $clog2(STRETCH) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rel && !s_q.done) begin
            s_d.cnt = s_q.cnt + CW'(1);
            if (s_q.cnt == CW'(STRETCH - 1)) s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign int_rst_n = s_q.done;

    // R1: the count never runs past the stretch length
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!arst_n)
        s_q.cnt <= CW'(STRETCH)) else $error("stretch count out of range");
    // R9: nothing counts before the synchronised release
    assert_no_early_count_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !rel |=> s_q.cnt == $past(s_q.cnt)) else $error("count moved before release");
endmodule

// File: rtl/core_clk_div.sv
module core_clk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic int_rst_n,
    output logic cpu_clk_en
);
    localparam int DW = $clog2(DIV);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == DW'(DIV - 1)) ? '0 : div_q + DW'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) div_q <= '0;
        else         div_q <= div_d;
    end

    assign cpu_clk_en = int_rst_n | (div_q == DW'(DIV - 1));

    // R2: during the stretch an enable pulse is never followed by another
    assert_slow_pulse_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (!int_rst_n && cpu_clk_en) |=> (!cpu_clk_en || int_rst_n))
        else $error("back-to-back core enables during reset");
endmodule

// File: rtl/release_seq.sv
module release_seq
    import rst_seq_pkg::*;
#(
    parameter int GRP_DLY  = 1,
    parameter int ECLK_DLY = 2,
    parameter int AUX_DLY  = 3,
    parameter int TICK_DLY = 4
) (
    input  logic    clk,
    input  logic    arst_n,
    input  logic    int_rst_n,
    output rel_en_t en
);
    localparam int SEQ_MAX = TICK_DLY;
    localparam int SW      = $clog2(SEQ_MAX + 1);

    logic [SW-1:0] seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (int_rst_n && seq_q < SW'(SEQ_MAX)) seq_d = seq_q + SW'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    always_comb begin
        en.grp  = seq_q >= SW'(GRP_DLY);
        en.eclk = seq_q >= SW'(ECLK_DLY);
        en.aux  = seq_q >= SW'(AUX_DLY);
        en.tick = seq_q >= SW'(TICK_DLY);
    end

    // R6: groups open only after the internal reset has ended
    assert_grp_after_rst_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(en.grp) |-> $past(int_rst_n)) else $error("groups opened during reset");
    // R7: clock outputs open in order, after the groups
    assert_clk_order_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (en.tick |-> en.aux) and (en.aux |-> en.eclk) and (en.eclk |-> en.grp))
        else $error("clock release order broken");
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int STRETCH  = 512,
    parameter int SYNC_STG = 2,
    parameter int DIV      = 8,
    parameter int GRP_DLY  = 1,
    parameter int ECLK_DLY = 2,
    parameter int AUX_DLY  = 3,
    parameter int TICK_DLY = 4
) (
    input  logic               clk_in,
    input  logic               ext_rst_n,
    input  logic [STRAP_W-1:0] boot_straps,
    input  logic               pll_wr_en,
    input  logic               pll_wr_engage,
    output logic               int_rst_n,
    output logic               cpu_clk_en,
    output logic [STRAP_W-1:0] boot_cfg,
    output logic               pll_bypass,
    output logic               mem_grp_oe,
    output logic               busreq_valid,
    output logic               ser_grp_oe,
    output logic               host_grp_oe,
    output logic               eclk_oe,
    output logic               aux_clk_oe,
    output logic               tick_clk_run
);
    typedef struct packed {
        logic [STRAP_W-1:0] cfg;
        logic               bypass;
    } cfg_t;

    logic    rel, rel_edge, stretch_done, div_en;
    rel_en_t en;
    cfg_t    c_d, c_q;

    rst_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk_in), .arst_n(ext_rst_n), .rel(rel), .rel_edge(rel_edge)
    );

    rst_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk(clk_in), .arst_n(ext_rst_n), .rel(rel), .int_rst_n(stretch_done)
    );

    core_clk_div #(.DIV(DIV)) u_div (
        .clk(clk_in), .arst_n(ext_rst_n), .int_rst_n(stretch_done), .cpu_clk_en(div_en)
    );

    release_seq #(
        .GRP_DLY(GRP_DLY), .ECLK_DLY(ECLK_DLY), .AUX_DLY(AUX_DLY), .TICK_DLY(TICK_DLY)
    ) u_seq (
        .clk(clk_in), .arst_n(ext_rst_n), .int_rst_n(stretch_done), .en(en)
    );

    always_comb begin
        c_d = c_q;
        if (rel_edge) c_d.cfg = boot_straps;
        if (stretch_done && pll_wr_en) c_d.bypass = ~pll_wr_engage;
    end

    always_ff @(posedge clk_in or negedge ext_rst_n) begin
        if (!ext_rst_n) c_q <= '{cfg: '0, bypass: 1'b1};
        else            c_q <= c_d;
    end

    // The external reset gates every pad control directly, with no clock edge in the path.
    assign int_rst_n    = stretch_done & ext_rst_n;
    assign cpu_clk_en   = div_en & ext_rst_n;
    assign boot_cfg     = c_q.cfg;
    assign pll_bypass   = c_q.bypass;
    assign mem_grp_oe   = en.grp & ext_rst_n;
    assign busreq_valid = en.grp & ext_rst_n;
    assign ser_grp_oe   = en.grp & ext_rst_n;
    assign host_grp_oe  = en.grp & ext_rst_n;
    assign eclk_oe      = en.eclk & ext_rst_n;
    assign aux_clk_oe   = en.aux & ext_rst_n;
    assign tick_clk_run = en.tick & ext_rst_n;

    // R1: the internal reset can only end after the synchronised release
    assert_rel_first_R1: assert property (@(posedge clk_in) disable iff (!ext_rst_n)
        stretch_done |-> rel) else $error("internal reset ended before release");
    // R3: the captured straps stay fixed once the release is seen
    assert_strap_hold_R3: assert property (@(posedge clk_in) disable iff (!ext_rst_n)
        (rel && $past(rel)) |-> $stable(c_q.cfg)) else $error("boot config changed");
    // R8: the PLL stays bypassed for the whole internal reset
    assert_bypass_in_rst_R8: assert property (@(posedge clk_in) disable iff (!ext_rst_n)
        !stretch_done |-> c_q.bypass) else $error("PLL left bypass during reset");
endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic [2:0] boot_straps = 3'b000;
    logic       pll_wr_en = 1'b0;
    logic       pll_wr_engage = 1'b0;
    logic       int_rst_n, cpu_clk_en, pll_bypass;
    logic [2:0] boot_cfg;
    logic       mem_grp_oe, busreq_valid, ser_grp_oe, host_grp_oe;
    logic       eclk_oe, aux_clk_oe, tick_clk_run;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    // reference state: edges since release, captured straps, bypass flag
    int         m_k = 0;
    logic [2:0] m_cap = 3'b000;
    logic       m_byp = 1'b1;

    always #2.5 clk = ~clk;

    rst_seq_ctrl uut (
        .clk_in(clk), .ext_rst_n(ext_rst_n), .boot_straps(boot_straps),
        .pll_wr_en(pll_wr_en), .pll_wr_engage(pll_wr_engage),
        .int_rst_n(int_rst_n), .cpu_clk_en(cpu_clk_en), .boot_cfg(boot_cfg),
        .pll_bypass(pll_bypass), .mem_grp_oe(mem_grp_oe), .busreq_valid(busreq_valid),
        .ser_grp_oe(ser_grp_oe), .host_grp_oe(host_grp_oe), .eclk_oe(eclk_oe),
        .aux_clk_oe(aux_clk_oe), .tick_clk_run(tick_clk_run)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            m_k   = 0;
            m_cap = 3'b000;
            m_byp = 1'b1;
        end else begin
            if (m_k >= 514 && pll_wr_en) m_byp = ~pll_wr_engage;
            if (m_k == 1) m_cap = boot_straps;
            m_k++;
        end
    end

    // compare everything against the model half a period after each edge
    always @(negedge clk) begin
        automatic bit live = ext_rst_n;
        automatic int k = live ? m_k : 0;
        chk("R1 R9 int_rst_n", int_rst_n, int'(live && k >= 514));
        chk("R2 cpu_clk_en", cpu_clk_en, int'(live && (k >= 514 || (k % 8) == 7)));
        chk("R3 boot_cfg", boot_cfg, live ? m_cap : 0);
        chk("R8 pll_bypass", pll_bypass, live ? m_byp : 1);
        chk("R4 R6 mem_grp_oe", mem_grp_oe, int'(live && k >= 515));
        chk("R4 R6 busreq_valid", busreq_valid, int'(live && k >= 515));
        chk("R5 R6 ser_grp_oe", ser_grp_oe, int'(live && k >= 515));
        chk("R5 R6 host_grp_oe", host_grp_oe, int'(live && k >= 515));
        chk("R7 eclk_oe", eclk_oe, int'(live && k >= 516));
        chk("R7 aux_clk_oe", aux_clk_oe, int'(live && k >= 517));
        chk("R7 tick_clk_run", tick_clk_run, int'(live && k >= 518));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pll_write(input logic engage);
        wait_cyc(1);
        pll_wr_en = 1'b1;
        pll_wr_engage = engage;
        wait_cyc(1);
        pll_wr_en = 1'b0;
    endtask

    initial begin
        wait_cyc(6);
        // first release with one strap pattern
        boot_straps = 3'b101;
        ext_rst_n = 1'b1;
        wait_cyc(100);
        pll_write(1'b1);              // R8: ignored during the stretch
        wait_cyc(20);
        boot_straps = 3'b010;         // R3: ignored after capture
        wait_cyc(420);
        pll_write(1'b1);              // R8: engage
        pll_write(1'b0);              // R8: back to bypass
        pll_write(1'b1);
        wait_cyc(5);
        // R4 R5: drop reset after full release, groups float at once
        ext_rst_n = 1'b0;
        #0.5;
        chk("R4 mem_grp_oe immediate", mem_grp_oe, 0);
        chk("R5 host_grp_oe immediate", host_grp_oe, 0);
        wait_cyc(4);
        boot_straps = 3'b011;
        ext_rst_n = 1'b1;
        wait_cyc(300);
        // R9: abort mid-stretch, then require a full new stretch
        ext_rst_n = 1'b0;
        wait_cyc(3);
        boot_straps = 3'b110;
        ext_rst_n = 1'b1;
        repeat (513) @(posedge clk);
        @(negedge clk);
        chk("R9 still in reset at E513", int_rst_n, 0);
        @(negedge clk);
        chk("R9 released at E514", int_rst_n, 1);
        wait_cyc(10);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule